// File: doc/BRIEF.md
# Vault Entry Access Controller

This block guards the entry side of a vault door. A visitor sets a 7-bit code on the switches and presses ENTER. When the door is shut and nobody is inside, the code is compared with a value fixed at build time. A match opens the door. The first mismatch sounds a slow alarm and allows one more attempt within a bounded window. A second mismatch, or letting that window run out, latches a trapped state with a fast alarm. Only the security reset clears the trapped state.

The door position is shown on a four-LED bar. Opening turns the LEDs off one per second. The door then stays fully open for a hold period and closes one LED per second. A master-open button and an open request from the exit-code logic can both start an opening. The block also keeps a saturating count of the people inside, driven by separate entry and exit strobes.

All push-button inputs arrive already debounced and synchronised, together with a 1 ms tick. Internally every duration counts quarter-second steps derived from that tick, so a bench can shorten them through parameters.

Top module: `vault_entry_ctrl`

## Requirements
- R1: After reset all door LEDs are lit (4'b1111), the alarm LEDs are dark, occupancy is 0 and door_open_o is low.
- R2: A rising edge on enter_i with code_i equal to CODE_VALUE, while the door is shut and occupancy is 0, starts a door opening on the same clock edge that samples the rising edge.
- R3: While opening, the lit LEDs form a run from bit 0 upward. One LED goes dark every second, bit 3 first, giving 0111, 0011, 0001, 0000. door_open_o rises when the bar reaches 0000.
- R4: The fully open door is held for HOLD_SEC seconds. door_open_o then falls and one LED lights per second, giving 0001, 0011, 0111, 1111; the door is shut again at 1111.
- R5: A first wrong code keeps the door shut and starts the slow alarm one cycle later. In the slow alarm all four alarm LEDs are lit for 1 s, then dark for 1 s, starting lit.
- R6: A correct code during the retry window opens the door, and the alarm LEDs go dark one cycle later.
- R7: A second wrong code, or RETRY_SEC seconds passing without a correct code, enters the trapped state. There all four alarm LEDs are lit for 0.25 s, then dark for 0.25 s, starting lit.
- R8: In the trapped state ENTER has no effect, even with the correct code: the door stays shut and the alarm keeps flashing.
- R9: sec_reset_i high returns the block from the retry or trapped state to idle. The alarm LEDs go dark, and a later correct code opens the door again.
- R10: A rising edge on door_master_i starts an opening from the shut or the closing state; a closing door reverses from its current bar position. A rising edge while the door is opening or held open changes nothing.
- R11: A rising edge on exit_open_i starts an opening exactly as door_master_i does.
- R12: A rising edge on entry_strobe_i raises occupancy_o by one and a rising edge on exit_strobe_i lowers it by one. Occupancy saturates at 0 and at MAX_OCC (9). Simultaneous edges on both strobes leave it unchanged.
- R13: ENTER is ignored while occupancy is non-zero: no opening, and no alarm even for a wrong code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| code_i | input | 7 | Entry code switches |
| enter_i | input | 1 | ENTER button, debounced level |
| sec_reset_i | input | 1 | Security reset button, level |
| door_master_i | input | 1 | Master door-open button, debounced level |
| exit_open_i | input | 1 | Open request from the exit-code logic |
| entry_strobe_i | input | 1 | Person-entering strobe, counts on its rising edge |
| exit_strobe_i | input | 1 | Person-leaving strobe, counts on its rising edge |
| door_led_o | output | 4 | Door position bar, 1111 = shut |
| alarm_led_o | output | 4 | Alarm indicator, all on or all off |
| occupancy_o | output | 4 | People inside, 0 to 9 |
| door_open_o | output | 1 | High while the door is fully open |

## Verification
The bench targets the point where the retry window times out against the slow flash phase. A timer that is off by one quarter would trap a cycle early or late, and a blinker that keeps its old phase on a mode change would start the fast flash dark. It presses a correct code during the trapped state, where a design that still decodes ENTER would open the door. It reverses a closing door with the master button, which a design that reloads the bar to full would reopen from the wrong position. It drives the occupancy count into both limits and applies both strobes together, where a wrapping or double-counting counter shows at the port.

// File: rtl/vault_pkg.sv
package vault_pkg;

    localparam int QTR_PER_SEC = 4;

    typedef enum logic [1:0] {
        DOOR_SHUT,
        DOOR_OPENING,
        DOOR_HELD,
        DOOR_CLOSING
    } door_state_e;

    typedef enum logic [1:0] {
        AUTH_IDLE,
        AUTH_RETRY,
        AUTH_TRAP
    } auth_state_e;

    typedef enum logic [1:0] {
        ALM_OFF,
        ALM_SLOW,
        ALM_FAST
    } alarm_mode_e;

endpackage

// File: rtl/vault_auth_fsm.sv
module vault_auth_fsm
    import vault_pkg::*;
#(
    parameter int               CODE_W     = 7,
    parameter logic [CODE_W-1:0] CODE_VALUE = 7'd90,
    parameter int               RETRY_Q    = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              qtr_i,
    input  logic              enter_pulse_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              ready_i,
    input  logic              sec_reset_i,
    output logic              open_go_o,
    output alarm_mode_e       mode_o,
    output auth_state_e       state_o
);

    localparam int RW = $clog2(RETRY_Q + 1);
    localparam logic [RW-1:0] RETRY_LAST = RW'(RETRY_Q - 1);

    typedef struct packed {
        auth_state_e    st;
        logic [RW-1:0]  win;
    } auth_regs_t;

    auth_regs_t cur_q, nxt_d;
    logic       attempt;
    logic       match;

    assign attempt = enter_pulse_i && ready_i;
    assign match   = (code_i == CODE_VALUE);

    always_comb begin
        nxt_d     = cur_q;
        open_go_o = 1'b0;
        if (sec_reset_i) begin
            nxt_d.st  = AUTH_IDLE;
            nxt_d.win = '0;
        end else begin
            case (cur_q.st)
                AUTH_IDLE: begin
                    if (attempt) begin
                        if (match) begin
                            open_go_o = 1'b1;
                        end else begin
                            nxt_d.st  = AUTH_RETRY;
                            nxt_d.win = '0;
                        end
                    end
                end
                AUTH_RETRY: begin
                    if (attempt && match) begin
                        open_go_o = 1'b1;
                        nxt_d.st  = AUTH_IDLE;
                    end else if (attempt) begin
                        nxt_d.st = AUTH_TRAP;
                    end else if (qtr_i) begin
                        if (cur_q.win == RETRY_LAST) begin
                            nxt_d.st = AUTH_TRAP;
                        end else begin
                            nxt_d.win = cur_q.win + 1'b1;
                        end
                    end
                end
                default: begin
                    nxt_d = cur_q;
                end
            endcase
        end
    end

    always_comb begin
        case (cur_q.st)
            AUTH_RETRY: mode_o = ALM_SLOW;
            AUTH_TRAP:  mode_o = ALM_FAST;
            default:    mode_o = ALM_OFF;
        endcase
    end

    assign state_o = cur_q.st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= AUTH_IDLE;
            cur_q.win <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/vault_door_seq.sv
module vault_door_seq
    import vault_pkg::*;
#(
    parameter int LED_N  = 4,
    parameter int STEP_Q = 4,
    parameter int HOLD_Q = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtr_i,
    input  logic             open_req_i,
    output logic [LED_N-1:0] led_o,
    output logic             open_o,
    output door_state_e      state_o
);

    localparam int LW = $clog2(LED_N + 1);
    localparam int SW = $clog2(STEP_Q + 1);
    localparam int HW = $clog2(HOLD_Q + 1);
    localparam logic [LW-1:0] LVL_FULL   = LW'(LED_N);
    localparam logic [LW-1:0] LVL_ONE    = LW'(1);
    localparam logic [LW-1:0] LVL_ALMOST = LW'(LED_N - 1);
    localparam logic [SW-1:0] STEP_LAST  = SW'(STEP_Q - 1);
    localparam logic [HW-1:0] HOLD_LAST  = HW'(HOLD_Q - 1);

    typedef struct packed {
        door_state_e    st;
        logic [LW-1:0]  lvl;
        logic [SW-1:0]  step;
        logic [HW-1:0]  hold;
    } door_regs_t;

    door_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            DOOR_SHUT: begin
                if (open_req_i) begin
                    nxt_d.st   = DOOR_OPENING;
                    nxt_d.step = '0;
                end
            end
            DOOR_OPENING: begin
                if (qtr_i) begin
                    if (cur_q.step == STEP_LAST) begin
                        nxt_d.step = '0;
                        nxt_d.lvl  = cur_q.lvl - 1'b1;
                        if (cur_q.lvl == LVL_ONE) begin
                            nxt_d.st   = DOOR_HELD;
                            nxt_d.hold = '0;
                        end
                    end else begin
                        nxt_d.step = cur_q.step + 1'b1;
                    end
                end
            end
            DOOR_HELD: begin
                if (qtr_i) begin
                    if (cur_q.hold == HOLD_LAST) begin
                        nxt_d.st   = DOOR_CLOSING;
                        nxt_d.step = '0;
                        nxt_d.hold = '0;
                    end else begin
                        nxt_d.hold = cur_q.hold + 1'b1;
                    end
                end
            end
            default: begin
                if (open_req_i) begin
                    nxt_d.st   = DOOR_OPENING;
                    nxt_d.step = '0;
                end else if (qtr_i) begin
                    if (cur_q.step == STEP_LAST) begin
                        nxt_d.step = '0;
                        nxt_d.lvl  = cur_q.lvl + 1'b1;
                        if (cur_q.lvl == LVL_ALMOST) begin
                            nxt_d.st = DOOR_SHUT;
                        end
                    end else begin
                        nxt_d.step = cur_q.step + 1'b1;
                    end
                end
            end
        endcase
    end

    for (genvar g = 0; g < LED_N; g++) begin : g_bar
        assign led_o[g] = (cur_q.lvl > LW'(g));
    end

    assign open_o  = (cur_q.st == DOOR_HELD);
    assign state_o = cur_q.st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st   <= DOOR_SHUT;
            cur_q.lvl  <= LVL_FULL;
            cur_q.step <= '0;
            cur_q.hold <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/vault_alarm_blink.sv
module vault_alarm_blink
    import vault_pkg::*;
#(
    parameter int LED_N       = 4,
    parameter int SLOW_HALF_Q = 4,
    parameter int FAST_HALF_Q = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qtr_i,
    input  alarm_mode_e      mode_i,
    output logic [LED_N-1:0] led_o
);

    localparam int CW = $clog2(SLOW_HALF_Q + 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_HALF_Q - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_HALF_Q - 1);

    typedef struct packed {
        alarm_mode_e    mode;
        logic [CW-1:0]  cnt;
        logic           lit;
    } blink_regs_t;

    blink_regs_t   cur_q, nxt_d;
    logic [CW-1:0] half_last;

    assign half_last = (cur_q.mode == ALM_FAST) ? FAST_LAST : SLOW_LAST;

    always_comb begin
        nxt_d = cur_q;
        if (mode_i != cur_q.mode) begin
            nxt_d.mode = mode_i;
            nxt_d.cnt  = '0;
            nxt_d.lit  = 1'b1;
        end else if (qtr_i && (cur_q.mode != ALM_OFF)) begin
            if (cur_q.cnt >= half_last) begin
                nxt_d.cnt = '0;
                nxt_d.lit = ~cur_q.lit;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    assign led_o = ((cur_q.mode != ALM_OFF) && cur_q.lit) ? '1 : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.mode <= ALM_OFF;
            cur_q.cnt  <= '0;
            cur_q.lit  <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/vault_occupancy.sv
module vault_occupancy #(
    parameter int MAX_OCC = 9,
    parameter int OCC_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             entry_i,
    input  logic             exit_i,
    output logic [OCC_W-1:0] count_o
);

    localparam logic [OCC_W-1:0] CAP = OCC_W'(MAX_OCC);

    typedef struct packed {
        logic             ent;
        logic             ext;
        logic [OCC_W-1:0] cnt;
    } occ_regs_t;

    occ_regs_t cur_q, nxt_d;
    logic      inc, dec;

    assign inc = entry_i && !cur_q.ent;
    assign dec = exit_i && !cur_q.ext;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.ent = entry_i;
        nxt_d.ext = exit_i;
        if (inc && !dec && (cur_q.cnt != CAP)) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end else if (dec && !inc && (cur_q.cnt != '0)) begin
            nxt_d.cnt = cur_q.cnt - 1'b1;
        end
    end

    assign count_o = cur_q.cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.ent <= 1'b0;
            cur_q.ext <= 1'b0;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

endmodule

// File: rtl/vault_entry_ctrl.sv
module vault_entry_ctrl
    import vault_pkg::*;
#(
    parameter int                CODE_W        = 7,
    parameter logic [CODE_W-1:0] CODE_VALUE    = 7'd90,
    parameter int                TICKS_PER_SEC = 1000,
    parameter int                RETRY_SEC     = 20,
    parameter int                HOLD_SEC      = 30,
    parameter int                LED_N         = 4,
    parameter int                MAX_OCC       = 9
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           tick_i,
    input  logic [CODE_W-1:0]              code_i,
    input  logic                           enter_i,
    input  logic                           sec_reset_i,
    input  logic                           door_master_i,
    input  logic                           exit_open_i,
    input  logic                           entry_strobe_i,
    input  logic                           exit_strobe_i,
    output logic [LED_N-1:0]               door_led_o,
    output logic [LED_N-1:0]               alarm_led_o,
    output logic [$clog2(MAX_OCC+1)-1:0]   occupancy_o,
    output logic                           door_open_o
);

    localparam int OCC_W     = $clog2(MAX_OCC + 1);
    localparam int QTR_TICKS = (TICKS_PER_SEC / QTR_PER_SEC < 1) ? 1 : TICKS_PER_SEC / QTR_PER_SEC;
    localparam int QW        = $clog2(QTR_TICKS + 1);
    localparam logic [QW-1:0] QTR_LAST = QW'(QTR_TICKS - 1);
    localparam int RETRY_Q   = RETRY_SEC * QTR_PER_SEC;
    localparam int HOLD_Q    = HOLD_SEC * QTR_PER_SEC;

    typedef struct packed {
        logic [QW-1:0] pre;
        logic          enter;
        logic          master;
        logic          exit_req;
    } top_regs_t;

    top_regs_t    cur_q, nxt_d;
    logic         qtr;
    logic         enter_rise, master_rise, exit_rise;
    logic         auth_open, open_req, ready;
    alarm_mode_e  alarm_mode;
    auth_state_e  auth_st;
    door_state_e  door_st;

    assign qtr         = tick_i && (cur_q.pre == QTR_LAST);
    assign enter_rise  = enter_i && !cur_q.enter;
    assign master_rise = door_master_i && !cur_q.master;
    assign exit_rise   = exit_open_i && !cur_q.exit_req;
    assign ready       = (door_st == DOOR_SHUT) && (occupancy_o == '0);
    assign open_req    = auth_open || master_rise || exit_rise;

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.enter    = enter_i;
        nxt_d.master   = door_master_i;
        nxt_d.exit_req = exit_open_i;
        if (tick_i) begin
            nxt_d.pre = qtr ? '0 : cur_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.pre      <= '0;
            cur_q.enter    <= 1'b0;
            cur_q.master   <= 1'b0;
            cur_q.exit_req <= 1'b0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    vault_auth_fsm #(
        .CODE_W     (CODE_W),
        .CODE_VALUE (CODE_VALUE),
        .RETRY_Q    (RETRY_Q)
    ) u_auth (
        .clk           (clk),
        .rst_n         (rst_n),
        .qtr_i         (qtr),
        .enter_pulse_i (enter_rise),
        .code_i        (code_i),
        .ready_i       (ready),
        .sec_reset_i   (sec_reset_i),
        .open_go_o     (auth_open),
        .mode_o        (alarm_mode),
        .state_o       (auth_st)
    );

    vault_door_seq #(
        .LED_N  (LED_N),
        .STEP_Q (QTR_PER_SEC),
        .HOLD_Q (HOLD_Q)
    ) u_door (
        .clk        (clk),
        .rst_n      (rst_n),
        .qtr_i      (qtr),
        .open_req_i (open_req),
        .led_o      (door_led_o),
        .open_o     (door_open_o),
        .state_o    (door_st)
    );

    vault_alarm_blink #(
        .LED_N       (LED_N),
        .SLOW_HALF_Q (QTR_PER_SEC),
        .FAST_HALF_Q (1)
    ) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .qtr_i  (qtr),
        .mode_i (alarm_mode),
        .led_o  (alarm_led_o)
    );

    vault_occupancy #(
        .MAX_OCC (MAX_OCC),
        .OCC_W   (OCC_W)
    ) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .entry_i (entry_strobe_i),
        .exit_i  (exit_strobe_i),
        .count_o (occupancy_o)
    );

endmodule

// File: rtl/vault_entry_ctrl_chk.sv
module vault_entry_ctrl_chk
    import vault_pkg::*;
#(
    parameter int LED_N   = 4,
    parameter int MAX_OCC = 9
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sec_reset_i,
    input logic [LED_N-1:0]             door_led_o,
    input logic [LED_N-1:0]             alarm_led_o,
    input logic [$clog2(MAX_OCC+1)-1:0] occupancy_o,
    input logic                         door_open_o,
    input auth_state_e                  auth_st
);

    p_occ_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy_o) <= MAX_OCC);

    p_occ_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy_o != $past(occupancy_o)) |->
        ((int'(occupancy_o) == int'($past(occupancy_o)) + 1) ||
         (int'(occupancy_o) + 1 == int'($past(occupancy_o)))));

    p_bar_shape_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (((int'(door_led_o) + 1) & int'(door_led_o)) == 0));

    p_bar_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (door_led_o != $past(door_led_o)) |->
        (($countones(door_led_o) == $countones($past(door_led_o)) + 1) ||
         ($countones(door_led_o) + 1 == $countones($past(door_led_o)))));

    p_open_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
        door_open_o |-> (door_led_o == '0));

    p_alarm_uniform_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_led_o == '0) || (alarm_led_o == '1));

    p_trap_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((auth_st == AUTH_TRAP) && !sec_reset_i) |=> (auth_st == AUTH_TRAP));

    p_reset_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sec_reset_i |=> (auth_st == AUTH_IDLE));

endmodule

bind vault_entry_ctrl vault_entry_ctrl_chk #(
    .LED_N   (LED_N),
    .MAX_OCC (MAX_OCC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sec_reset_i (sec_reset_i),
    .door_led_o  (door_led_o),
    .alarm_led_o (alarm_led_o),
    .occupancy_o (occupancy_o),
    .door_open_o (door_open_o),
    .auth_st     (auth_st)
);

// File: tb/vault_entry_ctrl_tb.sv
module vault_entry_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 4;
    localparam int RETRY_S    = 3;
    localparam int HOLD_S     = 2;
    localparam logic [6:0] GOOD_CODE = 7'b1011010;
    localparam logic [6:0] BAD_CODE  = 7'b0011010;

    localparam int K_DOOR  = 0;
    localparam int K_ALARM = 1;
    localparam int K_OCC   = 2;
    localparam int K_OPEN  = 3;

    localparam int IN_ENTER  = 0;
    localparam int IN_SRST   = 1;
    localparam int IN_MASTER = 2;
    localparam int IN_EXITOP = 3;
    localparam int IN_ENTRY  = 4;
    localparam int IN_EXIT   = 5;
    localparam int IN_BOTH   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic [6:0] code_i = '0;
    logic       enter_i = 1'b0;
    logic       sec_reset_i = 1'b0;
    logic       door_master_i = 1'b0;
    logic       exit_open_i = 1'b0;
    logic       entry_strobe_i = 1'b0;
    logic       exit_strobe_i = 1'b0;
    logic [3:0] door_led_o;
    logic [3:0] alarm_led_o;
    logic [3:0] occupancy_o;
    logic       door_open_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vault_entry_ctrl #(
        .CODE_W        (7),
        .CODE_VALUE    (GOOD_CODE),
        .TICKS_PER_SEC (TPS),
        .RETRY_SEC     (RETRY_S),
        .HOLD_SEC      (HOLD_S),
        .LED_N         (4),
        .MAX_OCC       (9)
    ) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick_i         (tick_i),
        .code_i         (code_i),
        .enter_i        (enter_i),
        .sec_reset_i    (sec_reset_i),
        .door_master_i  (door_master_i),
        .exit_open_i    (exit_open_i),
        .entry_strobe_i (entry_strobe_i),
        .exit_strobe_i  (exit_strobe_i),
        .door_led_o     (door_led_o),
        .alarm_led_o    (alarm_led_o),
        .occupancy_o    (occupancy_o),
        .door_open_o    (door_open_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    kind;
        int    val;
        string req;
    } exp_t;

    exp_t  sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 0;
    exp_t  mon_e;
    int    mon_act;

    task automatic expect_at(input int at, input int kind, input int val, input string req);
        exp_t e;
        int   i;
        e.at = at; e.kind = kind; e.val = val; e.req = req;
        i = sb.size();
        while (i > 0 && sb[i-1].at > at) i--;
        sb.insert(i, e);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            mon_e = sb.pop_front();
            case (mon_e.kind)
                K_DOOR:  mon_act = int'(door_led_o);
                K_ALARM: mon_act = int'(alarm_led_o);
                K_OCC:   mon_act = int'(occupancy_o);
                default: mon_act = int'(door_open_o);
            endcase
            n_cmp++;
            if (mon_e.at != cyc || mon_act != mon_e.val) begin
                n_bad++;
                $display("FAIL %s kind=%0d cycle=%0d: actual=%0d expected=%0d",
                         mon_e.req, mon_e.kind, mon_e.at, mon_act, mon_e.val);
            end
        end
    end

    task automatic set_in(input int which, input logic v);
        case (which)
            IN_ENTER:  enter_i = v;
            IN_SRST:   sec_reset_i = v;
            IN_MASTER: door_master_i = v;
            IN_EXITOP: exit_open_i = v;
            IN_ENTRY:  entry_strobe_i = v;
            IN_EXIT:   exit_strobe_i = v;
            default: begin
                entry_strobe_i = v;
                exit_strobe_i  = v;
            end
        endcase
    endtask

    task automatic press(input int which);
        set_in(which, 1'b1);
        @(negedge clk);
        set_in(which, 1'b0);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // full open-hold-close sequence, e = first cycle in the opening state
    task automatic expect_cycle(input int e, input string req);
        expect_at(e,      K_DOOR, 15, req);
        expect_at(e + 3,  K_DOOR, 15, "R3");
        expect_at(e + 4,  K_DOOR, 7,  "R3");
        expect_at(e + 8,  K_DOOR, 3,  "R3");
        expect_at(e + 12, K_DOOR, 1,  "R3");
        expect_at(e + 15, K_OPEN, 0,  "R3");
        expect_at(e + 16, K_DOOR, 0,  "R3");
        expect_at(e + 16, K_OPEN, 1,  "R3");
        expect_at(e + 23, K_OPEN, 1,  "R4");
        expect_at(e + 24, K_OPEN, 0,  "R4");
        expect_at(e + 28, K_DOOR, 1,  "R4");
        expect_at(e + 32, K_DOOR, 3,  "R4");
        expect_at(e + 36, K_DOOR, 7,  "R4");
        expect_at(e + 39, K_DOOR, 7,  "R4");
        expect_at(e + 40, K_DOOR, 15, "R4");
    endtask

    initial begin
        int c;
        int e;
        int occ_model;
        idle(3);
        rst_n = 1'b1;
        c = cyc;
        expect_at(c + 1, K_DOOR, 15, "R1");
        expect_at(c + 1, K_ALARM, 0, "R1");
        expect_at(c + 1, K_OCC, 0, "R1");
        expect_at(c + 1, K_OPEN, 0, "R1");
        idle(3);

        // R2: correct code opens, then R3/R4 sequence
        code_i = GOOD_CODE;
        c = cyc;
        expect_cycle(c + 1, "R2");
        expect_at(c + 4, K_ALARM, 0, "R2");
        press(IN_ENTER);
        idle(45);

        // R5 then R7 by timeout, R8 trapped, R9 reset
        code_i = BAD_CODE;
        c = cyc; e = c + 1;
        expect_at(e + 4,  K_DOOR, 15, "R5");
        expect_at(e + 1,  K_ALARM, 15, "R5");
        expect_at(e + 4,  K_ALARM, 15, "R5");
        expect_at(e + 5,  K_ALARM, 0, "R5");
        expect_at(e + 8,  K_ALARM, 0, "R5");
        expect_at(e + 9,  K_ALARM, 15, "R5");
        expect_at(e + 12, K_ALARM, 15, "R7");
        expect_at(e + 13, K_ALARM, 15, "R7");
        expect_at(e + 14, K_ALARM, 0, "R7");
        expect_at(e + 15, K_ALARM, 15, "R7");
        press(IN_ENTER);
        idle(19);
        // fast flash started lit at e+13, toggles every cycle
        code_i = GOOD_CODE;
        c = cyc;
        expect_at(c + 2, K_DOOR, 15, "R8");
        expect_at(c + 6, K_DOOR, 15, "R8");
        expect_at(c + 6, K_OPEN, 0, "R8");
        expect_at(c + 3, K_ALARM, (((c + 3 - (e + 13)) % 2) == 0) ? 15 : 0, "R8");
        expect_at(c + 4, K_ALARM, (((c + 4 - (e + 13)) % 2) == 0) ? 15 : 0, "R8");
        press(IN_ENTER);
        idle(6);
        c = cyc;
        expect_at(c + 2, K_ALARM, 0, "R9");
        expect_at(c + 6, K_ALARM, 0, "R9");
        press(IN_SRST);
        idle(6);
        c = cyc;
        expect_cycle(c + 1, "R9");
        press(IN_ENTER);
        idle(45);

        // R6: correct code inside retry window
        code_i = BAD_CODE;
        c = cyc;
        expect_at(c + 3, K_ALARM, 15, "R6");
        press(IN_ENTER);
        code_i = GOOD_CODE;
        idle(1);
        c = cyc;
        expect_cycle(c + 1, "R6");
        expect_at(c + 2, K_ALARM, 0, "R6");
        expect_at(c + 8, K_ALARM, 0, "R6");
        press(IN_ENTER);
        idle(45);

        // R7: second wrong code traps
        code_i = BAD_CODE;
        press(IN_ENTER);
        idle(1);
        c = cyc;
        expect_at(c + 2, K_ALARM, 15, "R7");
        expect_at(c + 3, K_ALARM, 0, "R7");
        expect_at(c + 4, K_ALARM, 15, "R7");
        expect_at(c + 5, K_DOOR, 15, "R7");
        press(IN_ENTER);
        idle(6);
        c = cyc;
        expect_at(c + 2, K_ALARM, 0, "R9");
        press(IN_SRST);
        idle(4);

        // R10: master from shut, ignored while opening, reverses closing
        c = cyc; e = c + 1;
        expect_at(e,      K_DOOR, 15, "R10");
        expect_at(e + 4,  K_DOOR, 7,  "R10");
        expect_at(e + 7,  K_DOOR, 7,  "R10");
        expect_at(e + 8,  K_DOOR, 3,  "R10");
        expect_at(e + 12, K_DOOR, 1,  "R10");
        expect_at(e + 16, K_DOOR, 0,  "R10");
        expect_at(e + 16, K_OPEN, 1,  "R10");
        expect_at(e + 24, K_OPEN, 0,  "R10");
        expect_at(e + 28, K_DOOR, 1,  "R10");
        expect_at(e + 33, K_DOOR, 1,  "R10");
        expect_at(e + 34, K_DOOR, 0,  "R10");
        expect_at(e + 34, K_OPEN, 1,  "R10");
        expect_at(e + 58, K_DOOR, 15, "R10");
        press(IN_MASTER);
        idle(3);
        press(IN_MASTER);
        while (cyc < e + 29) @(negedge clk);
        press(IN_MASTER);
        idle(35);

        // R11: exit-side open request
        c = cyc;
        expect_cycle(c + 1, "R11");
        press(IN_EXITOP);
        idle(45);

        // R12: occupancy up to the cap and past it
        occ_model = 0;
        for (int k = 0; k < 11; k++) begin
            c = cyc;
            if (occ_model < 9) occ_model++;
            expect_at(c + 1, K_OCC, occ_model, "R12");
            press(IN_ENTRY);
        end
        // R13: ENTER ignored while occupied
        code_i = GOOD_CODE;
        c = cyc;
        expect_at(c + 2, K_DOOR, 15, "R13");
        expect_at(c + 6, K_DOOR, 15, "R13");
        expect_at(c + 6, K_OPEN, 0, "R13");
        press(IN_ENTER);
        idle(6);
        code_i = BAD_CODE;
        c = cyc;
        expect_at(c + 3, K_ALARM, 0, "R13");
        expect_at(c + 6, K_ALARM, 0, "R13");
        press(IN_ENTER);
        idle(6);
        // R12: simultaneous strobes leave the count alone
        c = cyc;
        expect_at(c + 1, K_OCC, 9, "R12");
        expect_at(c + 2, K_OCC, 9, "R12");
        press(IN_BOTH);
        for (int k = 0; k < 11; k++) begin
            c = cyc;
            if (occ_model > 0) occ_model--;
            expect_at(c + 1, K_OCC, occ_model, "R12");
            press(IN_EXIT);
        end
        idle(5);

        while (sb.size() > 0) @(negedge clk);
        idle(2);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule